// File: doc/BRIEF.md
# Outbound Virtual Wire Group

This block holds one group of four outbound virtual wires. Local firmware sets the wire values, and the block reports them to a host. Firmware uses a two-word 32-bit register interface. The control word carries the group's host index, a reset-source selector and a reset pattern, and it exposes one read-only change flag per wire. The state word carries the four wire values, each at its own byte lane.

A wire's flag is set whenever a register write or a reset load gives that wire a new value. While any flag is set, the block raises a transmit request. It also presents its host index and the four current wire values. A transmitter accepts the report by asserting accept while the request is high. The block then clears the flags it reported. If a wire changes in the same cycle as the accept, its flag stays set so that the new value is reported later.

Four external reset inputs can each serve as the group's reset source. The selector picks one of them. On a rising edge of the chosen input, the four wires load from the reset pattern.

Top module: `vw_out_group`

## Requirements
- R1: After the synchronous reset, the control word reads 0x00000002 (index 2, source 0, pattern 0, no flags), the state word reads 0, and tx_req is low.
- R2: Control word layout: host index in bits 7:0, reset-source selector in bits 9:8, reset pattern in bits 15:12 (pattern bit i belongs to wire i), and change flags in bits 19:16. All other bits read zero. A written index below 2 is stored as 2.
- R3: In the state word, wire i sits at bit 8*i (bits 0, 8, 16, 24). All other bits read zero and ignore writes.
- R4: One clock edge after the reset input chosen by the selector goes from low to high, the wires hold the reset pattern (0 = all low, 15 = all high). A rising edge on an unselected input has no effect. An input that stays high loads nothing more. A load overrides a state-word write in the same cycle.
- R5: Flag i is set whenever wire i takes a value different from its current one. Writing a wire's present value sets nothing. Writes to bits 19:16 have no effect.
- R6: tx_req is high exactly while any flag is set, and it stays high until accepted. tx_index and tx_wires always show the current index and wire values.
- R7: On a cycle with tx_req and tx_ack both high, all flags clear unless the same cycle changes a wire.
- R8: A wire that changes in the same cycle as an accept keeps its flag set, and the flags of the other wires clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 1 | Write target: 0 control word, 1 state word |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 1 | Read target: 0 control word, 1 state word |
| reg_rd_data | output | 32 | Read data (combinational) |
| rst_src_in | input | 4 | Candidate reset inputs, synchronous to clk |
| tx_req | output | 1 | Report pending |
| tx_ack | input | 1 | Transmitter accepts the report |
| tx_index | output | 8 | Host index of the group |
| tx_wires | output | 4 | Current wire values |

## Verification
On every cycle, the assertions check the following. The host index never drops below its minimum. The wires stay still unless a state write or a reset-input change occurs. Any wire change is accompanied by a pending request. A request persists until it is accepted. An accept with no new stimulus leaves no request behind. Unused state-word bits read zero. Only the bench's scenarios show the exact field layouts, the clamp on write, the choice among reset inputs, the edge-only load, the priority of a load over a write, and the flag that survives an accept in the same cycle.

// File: rtl/vw_out_pkg.sv
package vw_out_pkg;

    localparam int VW_WIRES    = 4;
    localparam int VW_IDX_W    = 8;
    localparam int VW_SRC_W    = 2;
    localparam int VW_NUM_RST  = 4;
    localparam int VW_STRIDE   = 8;
    localparam int VW_DATA_W   = 32;

    localparam int F_SRC_LSB   = 8;
    localparam int F_PAT_LSB   = 12;
    localparam int F_FLAG_LSB  = 16;

    localparam logic [VW_IDX_W-1:0] VW_MIN_INDEX = 8'd2;

    typedef enum logic {
        ADDR_CTRL  = 1'b0,
        ADDR_STATE = 1'b1
    } vw_addr_e;

    typedef struct packed {
        logic [VW_WIRES-1:0] pattern;
        logic [VW_SRC_W-1:0] src;
        logic [VW_IDX_W-1:0] index;
    } vw_ctrl_t;

    function automatic logic [VW_IDX_W-1:0] clamp_index(input logic [VW_IDX_W-1:0] v);
        return (v < VW_MIN_INDEX) ? VW_MIN_INDEX : v;
    endfunction

    function automatic vw_ctrl_t ctrl_from_word(input logic [VW_DATA_W-1:0] w);
        vw_ctrl_t c;
        c.index   = clamp_index(w[VW_IDX_W-1:0]);
        c.src     = w[F_SRC_LSB +: VW_SRC_W];
        c.pattern = w[F_PAT_LSB +: VW_WIRES];
        return c;
    endfunction

    function automatic logic [VW_DATA_W-1:0] ctrl_to_word(input vw_ctrl_t c,
                                                          input logic [VW_WIRES-1:0] flags);
        logic [VW_DATA_W-1:0] w;
        w = '0;
        w[VW_IDX_W-1:0]             = c.index;
        w[F_SRC_LSB +: VW_SRC_W]    = c.src;
        w[F_PAT_LSB +: VW_WIRES]    = c.pattern;
        w[F_FLAG_LSB +: VW_WIRES]   = flags;
        return w;
    endfunction

    function automatic logic [VW_WIRES-1:0] wires_from_word(input logic [VW_DATA_W-1:0] w);
        logic [VW_WIRES-1:0] v;
        for (int i = 0; i < VW_WIRES; i++) v[i] = w[i*VW_STRIDE];
        return v;
    endfunction

    function automatic logic [VW_DATA_W-1:0] wires_to_word(input logic [VW_WIRES-1:0] v);
        logic [VW_DATA_W-1:0] w;
        w = '0;
        for (int i = 0; i < VW_WIRES; i++) w[i*VW_STRIDE] = v[i];
        return w;
    endfunction

endpackage

// File: rtl/vw_out_ctrl_reg.sv
module vw_out_ctrl_reg
    import vw_out_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [VW_DATA_W-1:0] wr_data,
    output vw_ctrl_t             ctrl
);
    vw_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.index   <= VW_MIN_INDEX;
            ctrl_q.src     <= '0;
            ctrl_q.pattern <= '0;
        end else if (wr_en) begin
            ctrl_q <= ctrl_from_word(wr_data);
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/vw_out_rst_edge.sv
module vw_out_rst_edge #(
    parameter int NUM_RST = 4,
    parameter int SRC_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_RST-1:0] rst_in,
    input  logic [SRC_W-1:0]   sel,
    output logic               load
);
    logic [NUM_RST-1:0] prev_q;
    logic [NUM_RST-1:0] rising;

    // Start high so an input already asserted at reset release loads nothing.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= rst_in;
    end

    assign rising = rst_in & ~prev_q;

    always_comb begin
        load = 1'b0;
        for (int i = 0; i < NUM_RST; i++) begin
            if (sel == SRC_W'(i)) load = rising[i];
        end
    end
endmodule

// File: rtl/vw_out_wires.sv
module vw_out_wires #(
    parameter int NUM_WIRES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [NUM_WIRES-1:0] wr_vals,
    input  logic                 load_en,
    input  logic [NUM_WIRES-1:0] load_vals,
    input  logic                 accept,
    output logic [NUM_WIRES-1:0] wires,
    output logic [NUM_WIRES-1:0] flags
);
    for (genvar i = 0; i < NUM_WIRES; i++) begin : g_wire
        logic nxt;
        logic val_q;
        logic flag_q;

        // Reset load wins over a firmware write in the same cycle.
        always_comb begin
            if (load_en)    nxt = load_vals[i];
            else if (wr_en) nxt = wr_vals[i];
            else            nxt = val_q;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q  <= 1'b0;
                flag_q <= 1'b0;
            end else begin
                val_q  <= nxt;
                flag_q <= (nxt != val_q) | (flag_q & ~accept);
            end
        end

        assign wires[i] = val_q;
        assign flags[i] = flag_q;
    end
endmodule

// File: rtl/vw_out_group.sv
module vw_out_group
    import vw_out_pkg::*;
#(
    parameter int NUM_WIRES = VW_WIRES,
    parameter int IDX_W     = VW_IDX_W,
    parameter int NUM_RST   = VW_NUM_RST,
    parameter int DATA_W    = VW_DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr_en,
    input  logic                 reg_wr_addr,
    input  logic [DATA_W-1:0]    reg_wr_data,
    input  logic                 reg_rd_addr,
    output logic [DATA_W-1:0]    reg_rd_data,
    input  logic [NUM_RST-1:0]   rst_src_in,
    output logic                 tx_req,
    input  logic                 tx_ack,
    output logic [IDX_W-1:0]     tx_index,
    output logic [NUM_WIRES-1:0] tx_wires
);
    localparam int SRC_W = $clog2(NUM_RST);

    vw_ctrl_t             ctrl;
    logic                 wr_ctrl;
    logic                 wr_state;
    logic                 load;
    logic                 accept;
    logic [NUM_WIRES-1:0] wires;
    logic [NUM_WIRES-1:0] flags;

    assign wr_ctrl  = reg_wr_en && (vw_addr_e'(reg_wr_addr) == ADDR_CTRL);
    assign wr_state = reg_wr_en && (vw_addr_e'(reg_wr_addr) == ADDR_STATE);

    vw_out_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_ctrl),
        .wr_data (reg_wr_data),
        .ctrl    (ctrl)
    );

    vw_out_rst_edge #(.NUM_RST(NUM_RST), .SRC_W(SRC_W)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .rst_in (rst_src_in),
        .sel    (ctrl.src),
        .load   (load)
    );

    vw_out_wires #(.NUM_WIRES(NUM_WIRES)) u_wires (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_state),
        .wr_vals   (wires_from_word(reg_wr_data)),
        .load_en   (load),
        .load_vals (ctrl.pattern),
        .accept    (accept),
        .wires     (wires),
        .flags     (flags)
    );

    assign tx_req   = |flags;
    assign accept   = tx_req & tx_ack;
    assign tx_index = ctrl.index;
    assign tx_wires = wires;

    assign reg_rd_data = (vw_addr_e'(reg_rd_addr) == ADDR_STATE) ? wires_to_word(wires)
                                                                 : ctrl_to_word(ctrl, flags);
endmodule

// File: rtl/vw_out_group_chk.sv
module vw_out_group_chk #(
    parameter int NUM_WIRES = 4,
    parameter int IDX_W     = 8,
    parameter int NUM_RST   = 4,
    parameter int DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reg_wr_en,
    input logic                 reg_wr_addr,
    input logic                 reg_rd_addr,
    input logic [DATA_W-1:0]    reg_rd_data,
    input logic [NUM_RST-1:0]   rst_src_in,
    input logic                 tx_req,
    input logic                 tx_ack,
    input logic [IDX_W-1:0]     tx_index,
    input logic [NUM_WIRES-1:0] tx_wires
);
    logic quiet;
    assign quiet = !(reg_wr_en && reg_wr_addr);

    AST_INDEX_AT_LEAST_MIN: assert property (@(posedge clk) disable iff (rst)
        tx_index >= IDX_W'(2)); // R2

    AST_STATE_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rd_addr |-> ((reg_rd_data & ~32'h01010101) == '0)); // R3

    AST_WIRES_STILL: assert property (@(posedge clk) disable iff (rst)
        (quiet && $stable(rst_src_in)) |=> $stable(tx_wires)); // R4

    AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        !$stable(tx_wires) |-> tx_req); // R5

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !tx_ack) |=> tx_req); // R6

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_ack && quiet && $stable(rst_src_in)) |=> !tx_req); // R7
endmodule

bind vw_out_group vw_out_group_chk #(
    .NUM_WIRES (NUM_WIRES),
    .IDX_W     (IDX_W),
    .NUM_RST   (NUM_RST),
    .DATA_W    (DATA_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_rd_addr (reg_rd_addr),
    .reg_rd_data (reg_rd_data),
    .rst_src_in  (rst_src_in),
    .tx_req      (tx_req),
    .tx_ack      (tx_ack),
    .tx_index    (tx_index),
    .tx_wires    (tx_wires)
);

// File: tb/vw_out_group_bench.sv
`timescale 1ns/1ps
module vw_out_group_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic        reg_wr_addr;
    logic [31:0] reg_wr_data;
    logic        reg_rd_addr;
    logic [31:0] reg_rd_data;
    logic [3:0]  rst_src_in;
    logic        tx_req;
    logic        tx_ack;
    logic [7:0]  tx_index;
    logic [3:0]  tx_wires;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    vw_out_group u_vw_out_group (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_addr (reg_wr_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_addr (reg_rd_addr),
        .reg_rd_data (reg_rd_data),
        .rst_src_in  (rst_src_in),
        .tx_req      (tx_req),
        .tx_ack      (tx_ack),
        .tx_index    (tx_index),
        .tx_wires    (tx_wires)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Drive a write for one edge; results are visible at the returning negedge.
    task automatic wr(input logic addr, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = addr; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic addr, input logic [31:0] exp);
        reg_rd_addr = addr;
        #1;
        check(tag, reg_rd_data, exp);
    endtask

    task automatic ack_pulse;
        @(negedge clk);
        tx_ack = 1'b1;
        @(negedge clk);
        tx_ack = 1'b0;
    endtask

    task automatic t_reset;
        rd_check("R1 ctrl after reset", 1'b0, 32'h0000_0002);
        rd_check("R1 state after reset", 1'b1, 32'h0);
        check("R1 tx_req after reset", {31'b0, tx_req}, 32'h0);
    endtask

    task automatic t_ctrl;
        wr(1'b0, 32'hFFFF_F3A5);
        rd_check("R2 ctrl fields", 1'b0, 32'h0000_F3A5);   // flag bits ignored too (R5)
        check("R5 no flag from ctrl write", {31'b0, tx_req}, 32'h0);
        wr(1'b0, 32'h0000_0001);
        rd_check("R2 index clamp", 1'b0, 32'h0000_0002);
        wr(1'b0, 32'h0000_0040);
        check("R6 tx_index", {24'b0, tx_index}, 32'h40);
    endtask

    task automatic t_state;
        wr(1'b1, 32'hFFFF_FFFF);
        rd_check("R3 state lanes", 1'b1, 32'h0101_0101);
        rd_check("R5 flags set", 1'b0, 32'h000F_0040);
        check("R6 tx_req on flags", {31'b0, tx_req}, 32'h1);
        check("R6 tx_wires", {28'b0, tx_wires}, 32'hF);
    endtask

    task automatic t_accept;
        repeat (3) @(negedge clk);
        check("R6 req held without ack", {31'b0, tx_req}, 32'h1);
        ack_pulse();
        check("R7 req cleared", {31'b0, tx_req}, 32'h0);
        rd_check("R7 flags cleared", 1'b0, 32'h0000_0040);
        wr(1'b1, 32'h0101_0101);
        rd_check("R5 same value no flag", 1'b0, 32'h0000_0040);
        wr(1'b1, 32'h0001_0000);
        rd_check("R5 changed wires flagged", 1'b0, 32'h000B_0040);
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        tx_ack = 1'b1;
        reg_wr_en = 1'b1; reg_wr_addr = 1'b1; reg_wr_data = 32'h0001_0001;
        @(negedge clk);
        tx_ack = 1'b0; reg_wr_en = 1'b0;
        rd_check("R8 new change survives accept", 1'b0, 32'h0001_0040);
        check("R8 tx_wires", {28'b0, tx_wires}, 32'h5);
        ack_pulse();
    endtask

    task automatic t_rst_load;
        wr(1'b0, 32'h0000_A240);          // pattern 1010, source 2
        @(negedge clk); rst_src_in[2] = 1'b1;
        @(negedge clk);
        rd_check("R4 load on selected edge", 1'b1, 32'h0100_0100);
        rd_check("R4 load flags", 1'b0, 32'h000F_A240);
        ack_pulse();
        wr(1'b1, 32'h0);                  // input still high: write stands
        rd_check("R4 level does not reload", 1'b1, 32'h0);
        ack_pulse();
        rst_src_in[2] = 1'b0;
        @(negedge clk); rst_src_in[1] = 1'b1;
        @(negedge clk);
        rd_check("R4 unselected input ignored", 1'b1, 32'h0);
        check("R4 no req from unselected", {31'b0, tx_req}, 32'h0);
        rst_src_in[1] = 1'b0;
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = 1'b1; reg_wr_data = 32'h0101_0101;
        rst_src_in[2] = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        rd_check("R4 load beats write", 1'b1, 32'h0100_0100);
        rd_check("R5 flags after load", 1'b0, 32'h000A_A240);
    endtask

    initial begin
        rst = 1'b1; reg_wr_en = 1'b0; reg_wr_addr = 1'b0; reg_wr_data = '0;
        reg_rd_addr = 1'b0; rst_src_in = '0; tx_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_state();
        t_accept();
        t_same_cycle();
        t_rst_load();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule